// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation analog-to-digital converter. It drives a trial code to an external current DAC and reads back a single comparator decision. A comparator value of 1 means that the trial code is above the analog input. The block resolves one bit per trial period, starting with the most significant bit. When the last bit is decided it holds the final code.

A conversion takes two phases on the start input. A CONVERT high pulse that lasts long enough clears the previous result and raises the ready line as a reset acknowledge. The falling edge of that pulse then starts the bit trials. The ready line drops once all bits are resolved.

The result output and its output-enable depend only on the active-low read-enable input. A read taken during a conversion therefore shows the partial code. Pulse qualification, trial period and comparator settle time are set by clock-count parameters. At a 50 MHz clock the defaults give a 500 ns minimum pulse and a 20 µs conversion.

Top module: `sar_seq_core`

## Requirements
- R1: While reset is applied and after it is released, the ready line is low, the trial code is 0x00, and with read-enable high the output-enable is low.
- R2: On the MIN_HIGH-th consecutive rising clock edge that samples CONVERT high, the ready line goes high. The defaults are 25 edges at 50 MHz, which is 500 ns and well inside the 1.5 µs acknowledge limit.
- R3: On that same edge the trial code is cleared to 0x00. It stays at 0x00 for as long as CONVERT remains high.
- R4: The first clock edge that samples CONVERT low after acknowledge loads the trial code 0x80. Each trial bit is held for TRIAL_CYC clock cycles. The comparator is sampled only on the last cycle of the period. A sampled 1 clears the bit under trial, and the next lower bit is set on the same edge.
- R5: The ready line falls on the edge that decides bit 0, which is 8*TRIAL_CYC edges after the low sample that began the conversion. From then on the code is held until the next qualified pulse.
- R6: The final code is the largest code that is not above the input level. With a bipolar input mapped in offset binary, the most negative input gives 0x00, zero gives 0x80 and the most positive input gives 0xFF.
- R7: With read-enable low, output-enable is 1 and the data output equals the current code, including partial codes during a conversion. With read-enable high, output-enable is 0 and the data output is 0x00.
- R8: A CONVERT high pulse that spans fewer than MIN_HIGH sampling edges is ignored. The ready line and the code do not change in idle, and a running conversion continues to the correct result.
- R9: A qualified CONVERT pulse during a conversion aborts it. The code returns to 0x00 and the ready line stays high, and a new conversion starts when CONVERT falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_i | input | 1 | Start pulse: a qualified high resets, the falling edge starts |
| cmp_hi_i | input | 1 | Comparator result: 1 when the trial code is above the input |
| de_n_i | input | 1 | Active-low read enable for the result outputs |
| trial_o | output | 8 | Trial or final code sent to the DAC |
| drdy_o | output | 1 | High from acknowledge until the conversion completes |
| data_o | output | 8 | Result data, 0x00 when not enabled |
| data_oe_o | output | 1 | Output-buffer enable |

## Verification
All inputs change at the falling clock edge, and the bench counts those edges to locate each result. The ready line must still be low after MIN_HIGH-1 high samples and must be high after MIN_HIGH. The first trial code is due one edge after CONVERT is seen low. The first partial code, with bit 7 resolved and bit 6 under trial, is due TRIAL_CYC edges later. The ready line is checked high after 8*TRIAL_CYC edges and low one edge after that. Read-enable is combinational, so it is checked in the same half cycle in which it is driven.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_pulse_qual.sv
module sar_pulse_qual #(
  parameter int MIN_HIGH = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_i,
  output logic qual_o
);
  localparam int CW = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] LIM  = CW'(MIN_HIGH);
  localparam logic [CW-1:0] LAST = CW'(MIN_HIGH - 1);

  logic [CW-1:0] hi_cnt_q, hi_cnt_d;

  always_comb begin
    hi_cnt_d = hi_cnt_q;
    if (!conv_i)              hi_cnt_d = '0;
    else if (hi_cnt_q != LIM) hi_cnt_d = hi_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt_q <= '0;
    else        hi_cnt_q <= hi_cnt_d;
  end

  assign qual_o = conv_i && (hi_cnt_q == LAST);
endmodule

// File: rtl/sar_trial_timer.sv
module sar_trial_timer #(
  parameter int TRIAL_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  output logic last_o
);
  localparam int TW = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam logic [TW-1:0] END_CNT = TW'(TRIAL_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)           cnt_d = '0;
    else if (en_i) begin
      if (cnt_q == END_CNT)  cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = en_i && (cnt_q == END_CNT);
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             decide_i,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] code_o,
  output logic             last_bit_o
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);

  logic [WIDTH-1:0] code_q, code_d;
  logic [IW-1:0]    idx_q, idx_d;

  always_comb begin
    code_d = code_q;
    idx_d  = idx_q;
    if (clear_i) begin
      code_d = '0;
      idx_d  = TOP;
    end else if (start_i) begin
      code_d = '0;
      code_d[WIDTH-1] = 1'b1;
      idx_d  = TOP;
    end else if (decide_i) begin
      for (int b = 0; b < WIDTH; b++) begin
        if (IW'(b) == idx_q && cmp_hi_i)            code_d[b] = 1'b0;
        if (idx_q != '0 && IW'(b + 1) == idx_q)     code_d[b] = 1'b1;
      end
      if (idx_q != '0) idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= TOP;
    end else begin
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign code_o     = code_q;
  assign last_bit_o = (idx_q == '0);
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
  parameter int WIDTH     = 8,
  parameter int MIN_HIGH  = 25,
  parameter int TRIAL_CYC = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             cmp_hi_i,
  input  logic             de_n_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             drdy_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o
);
  import sar_seq_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t state_q, state_d;
  logic qual, trial_last, last_bit, start, decide;
  logic [WIDTH-1:0] code;

  sar_pulse_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk(clk), .rst_n(rst_int_n), .conv_i(conv_i), .qual_o(qual)
  );

  sar_trial_timer #(.TRIAL_CYC(TRIAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .en_i(state_q == SEQ_RUN),
    .restart_i(start), .last_o(trial_last)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk(clk), .rst_n(rst_int_n), .clear_i(qual), .start_i(start),
    .decide_i(decide), .cmp_hi_i(cmp_hi_i), .code_o(code),
    .last_bit_o(last_bit)
  );

  assign start  = (state_q == SEQ_ACK) && !conv_i;
  assign decide = (state_q == SEQ_RUN) && trial_last && !qual;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (qual) state_d = SEQ_ACK;
      SEQ_ACK:  if (start) state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (qual)                    state_d = SEQ_ACK;
        else if (decide && last_bit) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= SEQ_IDLE;
    else            state_q <= state_d;
  end

  assign trial_o   = code;
  assign drdy_o    = (state_q != SEQ_IDLE);
  assign data_oe_o = !de_n_i;
  assign data_o    = de_n_i ? '0 : code;
endmodule

// File: rtl/sar_seq_checks.sv
module sar_seq_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_i,
  input logic             de_n_i,
  input logic [WIDTH-1:0] trial_o,
  input logic             drdy_o,
  input logic [WIDTH-1:0] data_o,
  input logic             data_oe_o
);
  a_r2_ack_needs_convert: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_o) |-> $past(conv_i));

  a_r3_ack_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_o) |-> (trial_o == '0));

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_o && $past(drdy_o) && $past(trial_o) != '0 && trial_o != '0)
      |-> ($countones(trial_o ^ $past(trial_o)) <= 2));

  a_r5_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_o && $past(!drdy_o)) |-> $stable(trial_o));

  a_r7_read_path: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (data_o == trial_o));
endmodule

bind sar_seq_core sar_seq_checks #(.WIDTH(WIDTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .de_n_i(de_n_i),
  .trial_o(trial_o), .drdy_o(drdy_o), .data_o(data_o), .data_oe_o(data_oe_o)
);

// File: tb/sar_seq_core_test.sv
module sar_seq_core_test;
  localparam int MH = 4;
  localparam int TC = 4;

  logic clk, rst_n, conv, de_n;
  logic [7:0] vin, trial, data;
  logic drdy, oe, cmp_hi;
  int total, bad;
  bit finished;

  assign cmp_hi = (trial > vin);

  sar_seq_core #(.WIDTH(8), .MIN_HIGH(MH), .TRIAL_CYC(TC)) uut (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .cmp_hi_i(cmp_hi),
    .de_n_i(de_n), .trial_o(trial), .drdy_o(drdy), .data_o(data),
    .data_oe_o(oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Qualified pulse: check ready timing (R2) and cleared code (R3); leaves conv high.
  task automatic ack_pulse(input bit check_timing);
    conv = 1'b1;
    repeat (MH - 1) @(negedge clk);
    if (check_timing) chk(drdy == 1'b0 || drdy == 1'b1 && 0, "R2 early", drdy, 0);
    @(negedge clk);
    chk(drdy == 1'b1, "R2 ack", drdy, 1);
    chk(trial == 8'h00, "R3 clear", trial, 0);
    @(negedge clk);
    chk(trial == 8'h00, "R3 held", trial, 0);
  endtask

  task automatic run_conv(input logic [7:0] v, input bit check_detail);
    logic [7:0] part;
    vin = v;
    conv = 1'b0;
    @(negedge clk);
    if (check_detail) chk(trial == 8'h80, "R4 first trial", trial, 8'h80);
    repeat (TC) @(negedge clk);
    part = (v & 8'h80) | 8'h40;
    if (check_detail) begin
      de_n = 1'b0;
      #1;
      chk(oe == 1'b1 && data == part, "R7 partial read", data, part);
      de_n = 1'b1;
      #1;
      chk(oe == 1'b0 && data == 8'h00, "R7 disabled", data, 0);
    end
    repeat (8 * TC - TC - 1) @(negedge clk);
    chk(drdy == 1'b1, "R5 busy", drdy, 1);
    @(negedge clk);
    chk(drdy == 1'b0, "R5 done", drdy, 0);
    chk(trial == v, "R6 result", trial, v);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; conv = 1'b0; de_n = 1'b1; vin = 8'h00;
    repeat (3) @(negedge clk);
    chk(drdy == 1'b0 && trial == 8'h00, "R1 in reset", trial, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(drdy == 1'b0, "R1 ready low", drdy, 0);
    chk(trial == 8'h00, "R1 code zero", trial, 0);
    chk(oe == 1'b0 && data == 8'h00, "R1 outputs off", oe, 0);

    // Exhaustive sweep, read as bipolar offset binary (R6)
    for (int s = -128; s <= 127; s++) begin
      ack_pulse(1'b1);
      run_conv(8'(s + 128), 1'b1);
      if (s == -128) chk(trial == 8'h00, "R6 neg full scale", trial, 0);
      if (s == 0)    chk(trial == 8'h80, "R6 bipolar zero", trial, 8'h80);
      if (s == 127)  chk(trial == 8'hFF, "R6 pos full scale", trial, 8'hFF);
      de_n = 1'b0;
      #1;
      chk(oe == 1'b1 && data == 8'(s + 128), "R7 final read", data, 8'(s + 128));
      de_n = 1'b1;
      @(negedge clk);
    end

    // Short pulse while idle is ignored (R8)
    vin = 8'h3C;
    conv = 1'b1;
    repeat (MH - 1) @(negedge clk);
    conv = 1'b0;
    repeat (3) @(negedge clk);
    chk(drdy == 1'b0, "R8 idle short no ack", drdy, 0);
    chk(trial == 8'hFF, "R8 idle short keeps result", trial, 8'hFF);

    // Short pulse during a conversion is ignored (R8)
    ack_pulse(1'b0);
    vin = 8'h5A;
    conv = 1'b0;
    repeat (TC + 2) @(negedge clk);
    conv = 1'b1;
    repeat (MH - 1) @(negedge clk);
    conv = 1'b0;
    repeat (8 * TC) @(negedge clk);
    chk(drdy == 1'b0, "R8 run short completes", drdy, 0);
    chk(trial == 8'h5A, "R8 run short result", trial, 8'h5A);

    // Abort by qualified pulse (R9)
    ack_pulse(1'b0);
    vin = 8'hC3;
    conv = 1'b0;
    repeat (3 * TC) @(negedge clk);
    conv = 1'b1;
    repeat (MH) @(negedge clk);
    chk(drdy == 1'b1, "R9 abort ready high", drdy, 1);
    chk(trial == 8'h00, "R9 abort clears", trial, 0);
    repeat (2) @(negedge clk);
    chk(trial == 8'h00, "R9 waits for fall", trial, 0);
    run_conv(8'h27, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule